// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block is the software-visible state of a 64-source vectored interrupt controller. A processor reaches it over a simple word-addressed bus with one write strobe, one read strobe and 32-bit data in each direction. Each of the 64 level inputs is edge-detected into a pending bit. Per-source enable and type bits, 4-bit priorities, a 5-bit normal mask and a control word decide which pending sources drive the normal request and which drive the fast request.

A built-in arbiter finds the winning source for each class. Reading one of the two vector words returns that winner and clears its pending bit in the same cycle. The handler then needs one read to both learn and acknowledge its source. Enables can be changed one bit at a time by writing a source number. Whole halves of the enable, type and pending vectors can also be written directly.

Read data is registered. It appears after the clock edge that samples the read strobe, and it holds its value while no read is issued.

Top module: `intc_regbank`

## Requirements
- R1: After reset, pending, enable, type, control, all priorities and read data are zero, the mask is 0x1F, and both request outputs are low.
- R2: Word 0 stores only write-data bits 24, 22, 21, 20, 19 and 18 (mask 0x017C0000). Every other bit reads back as zero.
- R3: Word 1 holds the normal mask, which is write-data bits [4:0]. It reads back zero-extended.
- R4: A write to word 2 sets the enable bit of source wdata[5:0], and a write to word 3 clears it. Both words read as zero.
- R5: Words 4 and 5 read and write bits 63..32 and 31..0 of the enable vector. Words 6 and 7 do the same for the type vector, where type 1 means fast and 0 means normal.
- R6: Source s has a 4-bit priority held in word 15 - s/8 at bits 4*(s%8)+3 .. 4*(s%8). Words 8 to 15 read back as written.
- R7: A pending bit is set on a rising edge of its source input and cleared on a falling edge. Words 18 (sources 63..32) and 19 (31..0) read the pending vector, and writes to them are ignored.
- R8: Writing word 20 or 21 replaces pending bits 63..32 or 31..0 with the write data. Both words read as zero.
- R9: Words 22 and 23 read the active normal sources (pending, enabled, type 0), high half then low half. Words 24 and 25 read the active fast sources (pending, enabled, type 1) in the same order. Writes to all four are ignored.
- R10: A read of word 16 returns the active normal source with the highest priority. Among equal priorities it picks the highest-numbered source. The value is (source << 16) | priority, or 0xFFFFFFFF when none is active, and the reported source's pending bit is cleared.
- R11: A read of word 17 returns the number of the lowest-numbered active fast source, or 0xFFFFFFFF when none is active. The reported source's pending bit is cleared.
- R12: `fast_irq` is high exactly when some fast source is active. `norm_irq` is high when some normal source is active and either the mask is 0x1F or that source's priority is greater than the mask.
- R13: When several updates hit one pending bit in the same cycle, a pending-half write wins over a vector-read clear, and a vector-read clear wins over a source edge.
- R14: Word 0x40 reads the constant 4. Every other unlisted word reads zero. Writes to words 16 to 19, word 0x40 and the rest of the space change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 64 | Level inputs from the interrupt sources |
| bus_addr | input | 10 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| norm_irq | output | 1 | Normal interrupt request |
| fast_irq | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 sources, 32-bit data and 4-bit priorities. The vector is therefore split into two halves, and each priority word covers eight sources. With these values the reversed priority-word order can be reached at both ends (sources 0..7 and 56..63). So can tie-breaking among equal priorities and the mask boundary, where a priority equal to the mask gives no request. The bench also drives same-cycle collisions between pending-half writes, vector-read clears and source edges on a single bit.

// File: rtl/intc_pkg.sv
// Shared register-map constants for the interrupt controller register bank.
// Assumes a fixed word-address space of 2**ADDR_W words.
package intc_pkg;
    localparam int ADDR_W = 10;
    typedef logic [ADDR_W-1:0] waddr_t;

    localparam waddr_t W_CTL        = 10'd0;
    localparam waddr_t W_MASK       = 10'd1;
    localparam waddr_t W_EN_SET     = 10'd2;
    localparam waddr_t W_EN_CLR     = 10'd3;
    localparam waddr_t W_EN_HI      = 10'd4;
    localparam waddr_t W_EN_LO      = 10'd5;
    localparam waddr_t W_TYP_HI     = 10'd6;
    localparam waddr_t W_TYP_LO     = 10'd7;
    localparam waddr_t W_PRIO_FIRST = 10'd8;
    localparam waddr_t W_PRIO_LAST  = 10'd15;
    localparam waddr_t W_VEC_NORM   = 10'd16;
    localparam waddr_t W_VEC_FAST   = 10'd17;
    localparam waddr_t W_RAW_HI     = 10'd18;
    localparam waddr_t W_RAW_LO     = 10'd19;
    localparam waddr_t W_FRC_HI     = 10'd20;
    localparam waddr_t W_FRC_LO     = 10'd21;
    localparam waddr_t W_ACTN_HI    = 10'd22;
    localparam waddr_t W_ACTN_LO    = 10'd23;
    localparam waddr_t W_ACTF_HI    = 10'd24;
    localparam waddr_t W_ACTF_LO    = 10'd25;
    localparam waddr_t W_CONST      = 10'h40;

    localparam int          MASK_W     = 5;
    localparam logic [31:0] CTL_WMASK  = 32'h017C_0000;
    localparam logic [31:0] CONST_WORD = 32'd4;
endpackage

// File: rtl/intc_pending.sv
// Pending-bit store with source edge detection.
// Per bit, a half write beats a vector-read clear, which beats a source edge.
// Assumes NUM_SRC is a multiple of DATA_W and at most 2*DATA_W.
module intc_pending #(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int IDW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               clr_en,
    input  logic [IDW-1:0]     clr_id,
    input  logic               frc_hi_we,
    input  logic               frc_lo_we,
    input  logic [DATA_W-1:0]  frc_data,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] src_q
);
    // Remember last source levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam int  BIT   = i % DATA_W;
        localparam bit  IN_HI = (i >= DATA_W);
        logic frc_we;
        assign frc_we = IN_HI ? frc_hi_we : frc_lo_we;

        // Update one pending bit by priority of its update sources
        always_ff @(posedge clk) begin
            if (!rst_n)                              pend_q[i] <= 1'b0;
            else if (frc_we)                         pend_q[i] <= frc_data[BIT];
            else if (clr_en && clr_id == IDW'(i))    pend_q[i] <= 1'b0;
            else if (src_in[i] && !src_q[i])         pend_q[i] <= 1'b1;
            else if (!src_in[i] && src_q[i])         pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Combinational arbiter: picks the normal winner (highest priority, highest
// number on ties), the fast winner (lowest number), and the two requests.
// Assumes MASK_W > PRIO_W.
module intc_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    parameter int IDW     = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC-1:0]        typ,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic [NUM_SRC-1:0]        act_norm,
    output logic [NUM_SRC-1:0]        act_fast,
    output logic                      norm_found,
    output logic [IDW-1:0]            norm_id,
    output logic [PRIO_W-1:0]         norm_prio,
    output logic                      fast_found,
    output logic [IDW-1:0]            fast_id,
    output logic                      norm_req,
    output logic                      fast_req
);
    assign act_norm = pend & en & ~typ;
    assign act_fast = pend & en & typ;

    // Normal winner: ascending scan with >= lets higher numbers win ties
    always_comb begin
        norm_found = 1'b0;
        norm_id    = '0;
        norm_prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_norm[i] && (!norm_found || prio_flat[i*PRIO_W +: PRIO_W] >= norm_prio)) begin
                norm_found = 1'b1;
                norm_id    = IDW'(i);
                norm_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // Fast winner: descending scan so the lowest number is kept last
    always_comb begin
        fast_found = 1'b0;
        fast_id    = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act_fast[i]) begin
                fast_found = 1'b1;
                fast_id    = IDW'(i);
            end
        end
    end

    // Request lines; an all-ones mask disables priority gating
    always_comb begin
        norm_req = norm_found &&
                   ((mask == '1) || ({{(MASK_W-PRIO_W){1'b0}}, norm_prio} > mask));
        fast_req = |act_fast;
    end
endmodule

// File: rtl/intc_regbank.sv
// Register bank of a vectored interrupt controller: control, mask, enable,
// type, priority and pending state behind a single-cycle word bus, with
// vector reads that acknowledge the reported source.
// Assumes NUM_SRC == 2*DATA_W and DATA_W == 32 for the fixed map.
module intc_regbank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int PRIO_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               norm_irq,
    output logic               fast_irq
);
    localparam int IDW           = $clog2(NUM_SRC);
    localparam int HALF          = DATA_W;
    localparam int VH            = DATA_W / 2;
    localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
    localparam int PRIO_WORDS    = NUM_SRC / PRIO_PER_WORD;
    localparam int PSEL_W        = $clog2(PRIO_WORDS);

    logic [DATA_W-1:0]         ctl_q;
    logic [MASK_W-1:0]         mask_q;
    logic [NUM_SRC-1:0]        en_q, en_nxt;
    logic [NUM_SRC-1:0]        typ_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]         prio_word [PRIO_WORDS];
    logic [NUM_SRC-1:0]        pend_q, src_prev;
    logic [NUM_SRC-1:0]        act_norm, act_fast;
    logic                      norm_found, fast_found;
    logic [IDW-1:0]            norm_id, fast_id, clr_id;
    logic [PRIO_W-1:0]         norm_prio;
    logic                      clr_en;
    logic [DATA_W-1:0]         norm_word, fast_word, rd_mux;
    logic [PSEL_W-1:0]         psel;
    logic                      prio_hit;

    // Control word and normal mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mask_q <= '1;
        end else begin
            if (bus_wr && bus_addr == W_CTL)  ctl_q  <= bus_wdata & DATA_W'(CTL_WMASK);
            if (bus_wr && bus_addr == W_MASK) mask_q <= bus_wdata[MASK_W-1:0];
        end
    end

    // Next enable vector from number-based and half-word writes
    always_comb begin
        en_nxt = en_q;
        if (bus_wr) begin
            case (bus_addr)
                W_EN_SET: en_nxt[bus_wdata[IDW-1:0]] = 1'b1;
                W_EN_CLR: en_nxt[bus_wdata[IDW-1:0]] = 1'b0;
                W_EN_HI:  en_nxt[NUM_SRC-1:HALF]     = bus_wdata;
                W_EN_LO:  en_nxt[HALF-1:0]           = bus_wdata;
                default:  ;
            endcase
        end
    end

    // Enable and type vector storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            typ_q <= '0;
        end else begin
            en_q <= en_nxt;
            if (bus_wr && bus_addr == W_TYP_HI) typ_q[NUM_SRC-1:HALF] <= bus_wdata;
            if (bus_wr && bus_addr == W_TYP_LO) typ_q[HALF-1:0]       <= bus_wdata;
        end
    end

    // Priority words; slot g sits at the reversed word address
    for (genvar g = 0; g < PRIO_WORDS; g++) begin : g_prio
        localparam waddr_t SLOT_ADDR = waddr_t'(int'(W_PRIO_LAST) - g);
        assign prio_word[g] = prio_q[g*DATA_W +: DATA_W];

        // Store one priority word
        always_ff @(posedge clk) begin
            if (!rst_n)                               prio_q[g*DATA_W +: DATA_W] <= '0;
            else if (bus_wr && bus_addr == SLOT_ADDR) prio_q[g*DATA_W +: DATA_W] <= bus_wdata;
        end
    end

    intc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .MASK_W  (MASK_W),
        .IDW     (IDW)
    ) u_arb (
        .pend       (pend_q),
        .en         (en_q),
        .typ        (typ_q),
        .prio_flat  (prio_q),
        .mask       (mask_q),
        .act_norm   (act_norm),
        .act_fast   (act_fast),
        .norm_found (norm_found),
        .norm_id    (norm_id),
        .norm_prio  (norm_prio),
        .fast_found (fast_found),
        .fast_id    (fast_id),
        .norm_req   (norm_irq),
        .fast_req   (fast_irq)
    );

    // Vector read acknowledge: clear the reported source
    always_comb begin
        clr_en = 1'b0;
        clr_id = norm_id;
        if (bus_rd && bus_addr == W_VEC_NORM && norm_found) begin
            clr_en = 1'b1;
            clr_id = norm_id;
        end else if (bus_rd && bus_addr == W_VEC_FAST && fast_found) begin
            clr_en = 1'b1;
            clr_id = fast_id;
        end
    end

    intc_pending #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .IDW     (IDW)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .clr_en    (clr_en),
        .clr_id    (clr_id),
        .frc_hi_we (bus_wr && bus_addr == W_FRC_HI),
        .frc_lo_we (bus_wr && bus_addr == W_FRC_LO),
        .frc_data  (bus_wdata),
        .pend_q    (pend_q),
        .src_q     (src_prev)
    );

    assign norm_word = norm_found ? {VH'(norm_id), VH'(norm_prio)} : '1;
    assign fast_word = fast_found ? DATA_W'(fast_id) : '1;
    assign psel      = PSEL_W'(W_PRIO_LAST - bus_addr);
    assign prio_hit  = (bus_addr >= W_PRIO_FIRST) && (bus_addr <= W_PRIO_LAST);

    // Read multiplexer over the word map
    always_comb begin
        rd_mux = '0;
        if (prio_hit) rd_mux = prio_word[psel];
        case (bus_addr)
            W_CTL:      rd_mux = ctl_q;
            W_MASK:     rd_mux = DATA_W'(mask_q);
            W_EN_HI:    rd_mux = en_q[NUM_SRC-1:HALF];
            W_EN_LO:    rd_mux = en_q[HALF-1:0];
            W_TYP_HI:   rd_mux = typ_q[NUM_SRC-1:HALF];
            W_TYP_LO:   rd_mux = typ_q[HALF-1:0];
            W_VEC_NORM: rd_mux = norm_word;
            W_VEC_FAST: rd_mux = fast_word;
            W_RAW_HI:   rd_mux = pend_q[NUM_SRC-1:HALF];
            W_RAW_LO:   rd_mux = pend_q[HALF-1:0];
            W_ACTN_HI:  rd_mux = act_norm[NUM_SRC-1:HALF];
            W_ACTN_LO:  rd_mux = act_norm[HALF-1:0];
            W_ACTF_HI:  rd_mux = act_fast[NUM_SRC-1:HALF];
            W_ACTF_LO:  rd_mux = act_fast[HALF-1:0];
            W_CONST:    rd_mux = DATA_W'(CONST_WORD);
            default:    ;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/intc_regbank_chk.sv
// Assertion checker for intc_regbank, attached by bind below.
// Assumes the default map: two halves of DATA_W sources each.
module intc_regbank_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int IDW     = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               norm_irq,
    input logic               fast_irq,
    input logic [NUM_SRC-1:0] src_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] typ_q,
    input logic [DATA_W-1:0]  ctl_q,
    input logic [MASK_W-1:0]  mask_q,
    input logic               norm_found,
    input logic [IDW-1:0]     norm_id,
    input logic               fast_found,
    input logic [IDW-1:0]     fast_id
);
    AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_CTL) |=> ctl_q == ($past(bus_wdata) & DATA_W'(CTL_WMASK))); // R2

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_EN_SET) |=> en_q[$past(bus_wdata[IDW-1:0])]); // R4

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_EN_CLR) |=> !en_q[$past(bus_wdata[IDW-1:0])]); // R4

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> ((pend_q & $past(src_in & ~src_q)) == $past(src_in & ~src_q))); // R7

    AST_NORM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == W_VEC_NORM && norm_found) |=> !pend_q[$past(norm_id)]); // R10

    AST_FAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == W_VEC_FAST && fast_found) |=> !pend_q[$past(fast_id)]); // R11

    AST_FAST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & en_q & typ_q)) |-> fast_irq); // R12

    AST_MASK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1 && |(pend_q & en_q & ~typ_q)) |-> norm_irq); // R12

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_FRC_LO) |=> pend_q[DATA_W-1:0] == $past(bus_wdata)); // R13

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R14
endmodule

bind intc_regbank intc_regbank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .norm_irq   (norm_irq),
    .fast_irq   (fast_irq),
    .src_q      (src_prev),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .typ_q      (typ_q),
    .ctl_q      (ctl_q),
    .mask_q     (mask_q),
    .norm_found (norm_found),
    .norm_id    (norm_id),
    .fast_found (fast_found),
    .fast_id    (fast_id)
);

// File: tb/intc_regbank_test.sv
`timescale 1ns/1ps
module intc_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [9:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nirq, firq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    intc_regbank uut (
        .clk (clk), .rst_n (rst_n), .src_in (src),
        .bus_addr (addr), .bus_wr (wr), .bus_rd (rd),
        .bus_wdata (wdata), .bus_rdata (rdata),
        .norm_irq (nirq), .fast_irq (firq)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_pend, m_en, m_typ, m_srcq, np, actn, actf;
    logic [31:0] m_ctl, m_rdata, r;
    int          m_mask, best, bid, clr;
    int          m_prio [64];

    function automatic logic model_nirq();
        logic any = 1'b0, hit = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (m_pend[i] && m_en[i] && !m_typ[i]) begin
                any = 1'b1;
                if (m_prio[i] > m_mask) hit = 1'b1;
            end
        end
        return (m_mask == 31) ? any : hit;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_typ = '0; m_srcq = '0;
            m_ctl = '0; m_rdata = '0; m_mask = 31;
            for (int i = 0; i < 64; i++) m_prio[i] = 0;
        end else begin
            actn = m_pend & m_en & ~m_typ;
            actf = m_pend & m_en & m_typ;
            clr = -1;
            if (rd) begin
                r = '0;
                if (addr >= 8 && addr <= 15)
                    for (int k = 0; k < 8; k++) r[4*k +: 4] = 4'(m_prio[(15 - addr) * 8 + k]);
                case (addr)
                    0: r = m_ctl;
                    1: r = 32'(m_mask);
                    4: r = m_en[63:32];  5: r = m_en[31:0];
                    6: r = m_typ[63:32]; 7: r = m_typ[31:0];
                    16: begin
                        best = -1; bid = -1;
                        for (int i = 63; i >= 0; i--)
                            if (actn[i] && m_prio[i] > best) begin best = m_prio[i]; bid = i; end
                        if (bid >= 0) begin r = 32'((bid << 16) | best); clr = bid; end
                        else r = 32'hFFFF_FFFF;
                    end
                    17: begin
                        bid = -1;
                        for (int i = 63; i >= 0; i--) if (actf[i]) bid = i;
                        if (bid >= 0) begin r = 32'(bid); clr = bid; end
                        else r = 32'hFFFF_FFFF;
                    end
                    18: r = m_pend[63:32]; 19: r = m_pend[31:0];
                    22: r = actn[63:32];   23: r = actn[31:0];
                    24: r = actf[63:32];   25: r = actf[31:0];
                    10'h40: r = 32'd4;
                    default: ;
                endcase
                m_rdata = r;
            end
            np = m_pend;
            for (int i = 0; i < 64; i++) begin
                if (src[i] && !m_srcq[i]) np[i] = 1'b1;
                if (!src[i] && m_srcq[i]) np[i] = 1'b0;
            end
            if (clr >= 0) np[clr] = 1'b0;
            if (wr) begin
                case (addr)
                    0: m_ctl = wdata & 32'h017C_0000;
                    1: m_mask = int'(wdata[4:0]);
                    2: m_en[wdata[5:0]] = 1'b1;
                    3: m_en[wdata[5:0]] = 1'b0;
                    4: m_en[63:32] = wdata;  5: m_en[31:0] = wdata;
                    6: m_typ[63:32] = wdata; 7: m_typ[31:0] = wdata;
                    20: np[63:32] = wdata;   21: np[31:0] = wdata;
                    default: if (addr >= 8 && addr <= 15)
                        for (int k = 0; k < 8; k++) m_prio[(15 - addr) * 8 + k] = int'(wdata[4*k +: 4]);
                endcase
            end
            m_pend = np;
            m_srcq = src;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Compare every cycle against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rdata, m_rdata, {cur_req, " rdata vs model"});
            chk({31'b0, nirq}, {31'b0, model_nirq()}, {cur_req, " norm_irq vs model"});
            chk({31'b0, firq}, {31'b0, |(m_pend & m_en & m_typ)}, {cur_req, " fast_irq vs model"});
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic wr_word(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk(rdata, exp, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        chk({30'b0, nirq, firq}, 32'h0, "R1 requests low after reset");
        rd_chk(0, 32'h0, "R1 control reset");
        rd_chk(1, 32'h1F, "R1 mask reset");
        rd_chk(5, 32'h0, "R1 enable reset");
        rd_chk(19, 32'h0, "R1 pending reset");
        rd_chk(15, 32'h0, "R1 priority reset");
        rd_chk(16, 32'hFFFF_FFFF, "R1 no normal vector");
        rd_chk(17, 32'hFFFF_FFFF, "R1 no fast vector");

        cur_req = "R2";
        wr_word(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h017C_0000, "R2 writable control bits");
        wr_word(0, 32'h0200_0000);
        rd_chk(0, 32'h0, "R2 bit 25 not stored");

        cur_req = "R3";
        wr_word(1, 32'hFFFF_FFE3);
        rd_chk(1, 32'h3, "R3 mask 5 bits");
        wr_word(1, 32'h1F);
        rd_chk(1, 32'h1F, "R3 mask restore");

        cur_req = "R4";
        wr_word(2, 32'h45);
        wr_word(2, 32'h3F);
        rd_chk(5, 32'h20, "R4 set by number low");
        rd_chk(4, 32'h8000_0000, "R4 set by number high");
        wr_word(3, 32'h05);
        rd_chk(5, 32'h0, "R4 clear by number");
        rd_chk(4, 32'h8000_0000, "R4 clear leaves other");
        rd_chk(2, 32'h0, "R4 set word reads zero");
        rd_chk(3, 32'h0, "R4 clear word reads zero");

        cur_req = "R5";
        wr_word(4, 32'h1234_5678);
        wr_word(5, 32'hFFFF_FFFF);
        rd_chk(4, 32'h1234_5678, "R5 enable high");
        rd_chk(5, 32'hFFFF_FFFF, "R5 enable low");
        wr_word(6, 32'hA5A5_0F0F);
        wr_word(7, 32'h0000_00C3);
        rd_chk(6, 32'hA5A5_0F0F, "R5 type high");
        rd_chk(7, 32'h0000_00C3, "R5 type low");
        wr_word(4, 32'hFFFF_FFFF);
        wr_word(6, 32'h0);
        wr_word(7, 32'h0);

        cur_req = "R6";
        wr_word(15, 32'h7654_3210);
        wr_word(8, 32'hFEDC_BA98);
        rd_chk(15, 32'h7654_3210, "R6 word 15");
        rd_chk(8, 32'hFEDC_BA98, "R6 word 8");
        rd_chk(9, 32'h0, "R6 word 9");
        wr_word(21, 32'h0000_0084);
        wr_word(20, 32'h0100_0000);
        rd_chk(16, 32'h0038_0008, "R6 source 56 priority 8");
        rd_chk(16, 32'h0007_0007, "R6 source 7 priority 7");
        rd_chk(16, 32'h0002_0002, "R6 source 2 priority 2");
        rd_chk(16, 32'hFFFF_FFFF, "R6 vectors drained");

        cur_req = "R7";
        @(negedge clk); src[3] = 1'b1; src[40] = 1'b1;
        rd_chk(19, 32'h8, "R7 rise sets low");
        rd_chk(18, 32'h100, "R7 rise sets high");
        @(negedge clk); src[3] = 1'b0;
        rd_chk(19, 32'h0, "R7 fall clears");
        wr_word(18, 32'hFFFF);
        rd_chk(18, 32'h100, "R7 raw high write ignored");
        wr_word(19, 32'h5);
        rd_chk(19, 32'h0, "R7 raw low write ignored");
        @(negedge clk); src[40] = 1'b0;
        rd_chk(18, 32'h0, "R7 fall clears high");

        cur_req = "R8";
        wr_word(21, 32'h0000_F000);
        rd_chk(19, 32'h0000_F000, "R8 force low");
        rd_chk(21, 32'h0, "R8 force low reads zero");
        wr_word(20, 32'h1);
        rd_chk(18, 32'h1, "R8 force high");
        rd_chk(20, 32'h0, "R8 force high reads zero");
        wr_word(20, 32'h0);

        cur_req = "R9";
        wr_word(7, 32'h0000_A000);
        wr_word(5, 32'h0000_7000);
        rd_chk(23, 32'h0000_5000, "R9 active normal low");
        rd_chk(25, 32'h0000_2000, "R9 active fast low");
        rd_chk(22, 32'h0, "R9 active normal high");
        rd_chk(24, 32'h0, "R9 active fast high");
        wr_word(23, 32'h0);
        rd_chk(23, 32'h0000_5000, "R9 view write ignored");
        wr_word(5, 32'hFFFF_FFFF);
        wr_word(7, 32'h0);

        cur_req = "R12";
        wr_word(14, 32'h2995_0000);
        wr_word(1, 32'h9);
        chk({31'b0, nirq}, 32'h0, "R12 priority equal to mask blocks");
        wr_word(1, 32'h8);
        chk({31'b0, nirq}, 32'h1, "R12 priority above mask requests");
        wr_word(1, 32'h1F);
        chk({31'b0, nirq}, 32'h1, "R12 mask all ones passes");

        cur_req = "R10";
        rd_chk(16, 32'h000E_0009, "R10 tie picks higher number");
        rd_chk(16, 32'h000D_0009, "R10 next tied source");
        rd_chk(16, 32'h000C_0005, "R10 next priority");
        rd_chk(16, 32'h000F_0002, "R10 lowest priority last");
        rd_chk(16, 32'hFFFF_FFFF, "R10 none left");
        rd_chk(19, 32'h0, "R10 pops cleared pending");
        chk({31'b0, nirq}, 32'h0, "R10 request drops");

        cur_req = "R11";
        wr_word(7, 32'h0000_0210);
        wr_word(21, 32'h0000_0230);
        chk({31'b0, firq}, 32'h1, "R11 fast request");
        rd_chk(17, 32'h4, "R11 lowest fast first");
        rd_chk(17, 32'h9, "R11 next fast");
        rd_chk(17, 32'hFFFF_FFFF, "R11 no fast left");
        chk({31'b0, firq}, 32'h0, "R11 fast request drops");
        rd_chk(19, 32'h20, "R11 normal source untouched");
        wr_word(21, 32'h0);
        wr_word(7, 32'h0);

        cur_req = "R13";
        @(negedge clk); src[7] = 1'b1; addr = 21; wdata = 32'h0; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rd_chk(19, 32'h0, "R13 force beats rising edge");
        @(negedge clk); src[7] = 1'b0;
        wr_word(13, 32'h000F_0000);
        wr_word(21, 32'h0010_0000);
        @(negedge clk); src[20] = 1'b1; addr = 16; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk(rdata, 32'h0014_000F, "R13 vector while source rises");
        rd_chk(19, 32'h0, "R13 read clear beats rising edge");
        @(negedge clk); src[20] = 1'b0; addr = 21; wdata = 32'h0010_0000; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rd_chk(19, 32'h0010_0000, "R13 force beats falling edge");
        wr_word(21, 32'h0);

        cur_req = "R14";
        rd_chk(10'h40, 32'h4, "R14 constant word");
        rd_chk(10'h3FF, 32'h0, "R14 unmapped top");
        rd_chk(26, 32'h0, "R14 unmapped after views");
        wr_word(10'h41, 32'hFFFF_FFFF);
        wr_word(10'h80, 32'hFFFF_FFFF);
        wr_word(16, 32'h0);
        wr_word(10'h40, 32'h0);
        rd_chk(10'h41, 32'h0, "R14 table write ignored");
        rd_chk(10'h40, 32'h4, "R14 constant unchanged");
        rd_chk(1, 32'h1F, "R14 mask unchanged");
        rd_chk(19, 32'h0, "R14 pending unchanged");
        idle(3);
        chk(rdata, 32'h1F_FFFF & 32'h0, "R14 rdata holds last read");

        summary();
    end
endmodule